// File: doc/BRIEF.md
# Embedded Operation Polling Status Generator

This block forms the status bits that a flash memory returns on its data bus when the host reads it while an embedded program or erase algorithm runs, together with the ready/busy indication. The command state machine reports the current busy mode, the write-pulse count of the command sequence and the last programmed data word. The host's read strobe and an internal time-limit flag complete the inputs. From these the block derives three status bits and a drive enable for an active-low, open-drain-style busy output.

The status is operation dependent. A program reports the inverse of the top bit of the programmed word until it finishes, and the true bit afterwards. An erase reports 0 until it finishes and 1 afterwards. A toggle bit inverts on every read while busy. A failure bit latches when the time limit is exceeded. Polling and busy become valid only once the command sequence has delivered enough write pulses: 4 for a program and 6 for an erase.

Top module: `flash_poll_status`

## Requirements
- R1: After reset, stat_q6 = 0, stat_q5 = 0, rb_drive_low = 0, and with op_mode idle stat_q7 equals bit DW-1 of last_data.
- R2: With op_mode = 2'b01 (program) and wr_cnt >= PROG_PULSES (4), the block is busy and stat_q7 is the inverse of bit DW-1 of last_data.
- R3: With op_mode = 2'b10 (erase algorithm) or 2'b11 (sector-erase time-out window) and wr_cnt >= ERASE_PULSES (6), the block is busy and stat_q7 = 0.
- R4: A non-idle op_mode with wr_cnt below its threshold is not busy: rb_drive_low = 0 and rd_stb does not change stat_q6.
- R5: When not busy and the most recent busy operation was a program (or none has occurred), stat_q7 equals bit DW-1 of last_data.
- R6: When not busy and the most recent busy operation was an erase, stat_q7 = 1.
- R7: Each clock edge with rd_stb high while busy inverts stat_q6.
- R8: While not busy, stat_q6 holds its value whatever rd_stb does.
- R9: limit_hit sampled high while busy sets stat_q5 from the next cycle. stat_q5 then holds until the first busy cycle of a later operation, after which it reads 0.
- R10: limit_hit while not busy leaves stat_q5 unchanged.
- R11: rb_drive_low is 1 exactly while busy (R2 or R3) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 2 | 00 idle, 01 program, 10 erase algorithm, 11 erase time-out window |
| last_data | input | DW | Data word last programmed |
| rd_stb | input | 1 | One-cycle read strobe from the host |
| wr_cnt | input | CW | Write pulses received in the current command sequence |
| limit_hit | input | 1 | Internal time limit exceeded |
| stat_q7 | output | 1 | Data-polling bit |
| stat_q6 | output | 1 | Toggle bit |
| stat_q5 | output | 1 | Time-limit failure bit |
| rb_drive_low | output | 1 | Drive enable pulling the ready/busy line low |

## Verification
The bench builds the block with its defaults: an 8-bit data word, a 3-bit pulse counter, and thresholds of 4 and 6. With these values both thresholds, the counts just below them and the counter's top value 7 can all be driven. The bench covers both erase sub-modes and the handover of the failure flag from one operation to the next.

// File: rtl/flash_poll_status.sv
module flash_poll_status #(
  parameter int DW           = 8,
  parameter int CW           = 3,
  parameter int PROG_PULSES  = 4,
  parameter int ERASE_PULSES = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_mode,
  input  logic [DW-1:0] last_data,
  input  logic          rd_stb,
  input  logic [CW-1:0] wr_cnt,
  input  logic          limit_hit,
  output logic          stat_q7,
  output logic          stat_q6,
  output logic          stat_q5,
  output logic          rb_drive_low
);
  localparam logic [1:0] M_PROG = 2'b01;
  localparam int         MSB    = DW - 1;

  logic prog_busy, erase_busy, busy;
  logic tog, fail, busy_q, last_erase;

  assign prog_busy  = (op_mode == M_PROG) && (int'(wr_cnt) >= PROG_PULSES);
  assign erase_busy = op_mode[1] && (int'(wr_cnt) >= ERASE_PULSES);
  assign busy       = prog_busy || erase_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog        <= 1'b0;
      fail       <= 1'b0;
      busy_q     <= 1'b0;
      last_erase <= 1'b0;
    end else begin
      busy_q <= busy;
      if (busy && rd_stb) tog <= ~tog;
      if (busy && limit_hit) fail <= 1'b1;
      else if (busy && !busy_q) fail <= 1'b0;
      if (busy) last_erase <= erase_busy;
    end
  end

  assign stat_q7      = erase_busy ? 1'b0 :
                        prog_busy  ? ~last_data[MSB] :
                        last_erase ? 1'b1 : last_data[MSB];
  assign stat_q6      = tog;
  assign stat_q5      = fail;
  assign rb_drive_low = busy;

  // R7
  property p_flip;
    @(posedge clk) disable iff (!rst_n) (rb_drive_low && rd_stb) |=> (stat_q6 != $past(stat_q6));
  endproperty
  q6_flip_chk: assert property (p_flip);

  // R8
  property p_hold;
    @(posedge clk) disable iff (!rst_n) (!rb_drive_low || !rd_stb) |=> $stable(stat_q6);
  endproperty
  q6_hold_chk: assert property (p_hold);

  // R9
  property p_fail_set;
    @(posedge clk) disable iff (!rst_n) (rb_drive_low && limit_hit) |=> stat_q5;
  endproperty
  q5_set_chk: assert property (p_fail_set);

  // R10
  property p_fail_idle;
    @(posedge clk) disable iff (!rst_n) !rb_drive_low |=> (stat_q5 == $past(stat_q5));
  endproperty
  q5_idle_chk: assert property (p_fail_idle);

  // R3
  property p_erase_q7;
    @(posedge clk) disable iff (!rst_n) (op_mode[1] && rb_drive_low) |-> !stat_q7;
  endproperty
  q7_erase_chk: assert property (p_erase_q7);

  // R11
  property p_rb_mode;
    @(posedge clk) disable iff (!rst_n) rb_drive_low |-> (op_mode != 2'b00);
  endproperty
  rb_mode_chk: assert property (p_rb_mode);
endmodule

// File: tb/flash_poll_status_test.sv
module flash_poll_status_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] op_mode = 2'b00;
  logic [7:0] last_data = 8'h80;
  logic rd_stb = 1'b0, limit_hit = 1'b0;
  logic [2:0] wr_cnt = 3'd0;
  logic stat_q7, stat_q6, stat_q5, rb_drive_low;

  always #10 clk = ~clk;

  flash_poll_status uut (.clk(clk), .rst_n(rst_n), .op_mode(op_mode), .last_data(last_data),
    .rd_stb(rd_stb), .wr_cnt(wr_cnt), .limit_hit(limit_hit), .stat_q7(stat_q7),
    .stat_q6(stat_q6), .stat_q5(stat_q5), .rb_drive_low(rb_drive_low));

  typedef struct { logic q7; logic q6; logic q5; logic rb; string tag; } exp_t;
  exp_t sb[$];
  event ev;
  int compared = 0, mismatched = 0;
  bit done = 0;

  logic m_tog = 0, m_fail = 0, m_prevbusy = 0, m_erase = 0;

  task automatic step(input logic [1:0] m, input logic [7:0] d, input logic rd,
                      input logic [2:0] c, input logic lim, input string tag);
    exp_t e;
    logic pb, eb, b;
    @(negedge clk);
    op_mode = m; last_data = d; rd_stb = rd; wr_cnt = c; limit_hit = lim;
    pb = (m == 2'b01) && (c >= 3'd4);
    eb = (m == 2'b10 || m == 2'b11) && (c >= 3'd6);
    b  = pb || eb;
    e.q7 = eb ? 1'b0 : pb ? ~d[7] : m_erase ? 1'b1 : d[7];
    e.q6 = m_tog; e.q5 = m_fail; e.rb = b; e.tag = tag;
    sb.push_back(e);
    -> ev;
    @(posedge clk);
    if (b && rd) m_tog = ~m_tog;
    if (b && lim) m_fail = 1'b1;
    else if (b && !m_prevbusy) m_fail = 1'b0;
    if (b) m_erase = eb;
    m_prevbusy = b;
  endtask

  initial begin
    forever begin
      exp_t e;
      @(ev);
      #2;
      e = sb.pop_front();
      compared++;
      if ({stat_q7, stat_q6, stat_q5, rb_drive_low} !== {e.q7, e.q6, e.q5, e.rb}) begin
        mismatched++;
        $display("FAIL %s: q7/q6/q5/rb got %b%b%b%b expected %b%b%b%b", e.tag,
                 stat_q7, stat_q6, stat_q5, rb_drive_low, e.q7, e.q6, e.q5, e.rb);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(2'b00, 8'h80, 0, 0, 0, "R1 reset idle");
    step(2'b00, 8'h35, 0, 0, 0, "R1 R5 idle true bit");
    step(2'b01, 8'hA5, 1, 3, 0, "R4 program below threshold");
    step(2'b01, 8'hA5, 0, 3, 0, "R4 no toggle below threshold");
    step(2'b01, 8'hA5, 1, 4, 0, "R2 R11 program busy");
    step(2'b01, 8'hA5, 1, 4, 0, "R7 toggle after read");
    step(2'b01, 8'h25, 0, 5, 0, "R2 R7 inverted bit low data");
    step(2'b01, 8'h25, 0, 7, 1, "R2 limit while busy");
    step(2'b01, 8'h25, 1, 7, 0, "R9 q5 set");
    step(2'b00, 8'h25, 1, 0, 0, "R5 R9 program done true bit");
    step(2'b00, 8'hA5, 1, 0, 0, "R8 R5 hold while idle");
    step(2'b10, 8'hA5, 1, 5, 0, "R4 erase below threshold");
    step(2'b10, 8'hA5, 1, 6, 0, "R3 R9 erase busy first cycle");
    step(2'b10, 8'hA5, 0, 6, 0, "R3 R9 q5 cleared new op");
    step(2'b11, 8'hA5, 1, 7, 0, "R3 R11 time-out window busy");
    step(2'b00, 8'h25, 0, 0, 1, "R6 erase done reads one");
    step(2'b00, 8'h25, 1, 0, 0, "R10 R8 idle limit ignored");
    step(2'b11, 8'h25, 0, 5, 1, "R4 R10 time-out below threshold");
    step(2'b00, 8'h25, 0, 0, 0, "R10 q5 still clear");
    step(2'b01, 8'hC3, 0, 4, 0, "R2 program after erase");
    step(2'b00, 8'h43, 0, 0, 0, "R5 idle after program");
    step(2'b10, 8'h43, 0, 7, 1, "R3 erase with limit");
    step(2'b10, 8'h43, 1, 7, 0, "R9 q5 set erase");
    step(2'b00, 8'h43, 0, 0, 0, "R6 R9 q5 held idle");
    step(2'b00, 8'h43, 0, 0, 0, "R11 released idle");
    #5;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule